// File: doc/BRIEF.md
# CAN Controller Mode Sequencer with Bus Integration

This block moves a CAN controller between a configuration mode and a normal operating mode. The host holds a configuration-request level. The block answers with an acknowledge status that changes only on bit boundaries, so a frame already on the wire is never cut short. While acknowledge is high, the block passes host writes for the bit-timing and acceptance-mask registers to those registers. While acknowledge is low, it blocks them.

When the host drops the request, the acknowledge falls at the next bit boundary. The node then enters bus integration. It counts consecutive recessive samples delivered by the bit-timing unit's strobe. Any dominant sample restarts the count. Once the count reaches the run length, the node becomes bus-active. Until then, its transmit output is forced recessive.

The transmit pin stage has a drive-mode bit that resets to open-drain. In open-drain mode, the output enable is asserted only for dominant bits. In push-pull mode, the level is driven continuously.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset, cfg_ack_o = 0, bus_active_o = 0, cfg_wr_en_o = 0, the drive mode is open-drain, and the node is in bus integration with a recessive count of zero.
- R2: When cfg_req_i = 1 at a clock edge where bit_strobe_i = 1, cfg_ack_o reads 1 from the following cycle.
- R3: cfg_ack_o changes only in the cycle after a clock edge with bit_strobe_i = 1; a request change without a strobe leaves it unchanged.
- R4: When cfg_req_i = 0 at a strobe edge while acknowledged, cfg_ack_o reads 0 from the following cycle, and the node starts bus integration with a count of zero.
- R5: During integration, bus_active_o becomes 1 in the cycle after the 11th consecutive strobe that samples rx_bit_i = 1 (recessive); after 10 such strobes it is still 0.
- R6: A strobe that samples rx_bit_i = 0 (dominant) during integration resets the recessive count to zero.
- R7: A request seen at a strobe during integration or while bus-active enters configuration mode, and bus_active_o reads 0 from the next cycle.
- R8: cfg_wr_en_o equals cfg_wr_i while cfg_ack_o = 1 and is 0 otherwise.
- R9: A pulse on drive_wr_i loads drive_pp_i into the drive-mode bit (1 = push-pull, 0 = open-drain); the new mode applies from the next cycle.
- R10: In open-drain mode, tx_pin_o = 0 and tx_oe_o = 1 only when bus_active_o = 1 and tx_bit_i = 0; otherwise tx_oe_o = 0.
- R11: In push-pull mode, tx_oe_o = 1, and tx_pin_o equals tx_bit_i when bus-active and is 1 (recessive) otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req_i | input | 1 | Host configuration-request level |
| bit_strobe_i | input | 1 | One-cycle pulse at each bit's sample point |
| rx_bit_i | input | 1 | Sampled receive bit (1 = recessive) |
| cfg_wr_i | input | 1 | Host write strobe for timing and mask registers |
| drive_wr_i | input | 1 | Host write strobe for the drive-mode bit |
| drive_pp_i | input | 1 | Drive-mode value (1 = push-pull) |
| tx_bit_i | input | 1 | Bit the protocol engine wants to send |
| cfg_ack_o | output | 1 | Configuration-mode acknowledge |
| cfg_wr_en_o | output | 1 | Write enable for timing and mask registers |
| bus_active_o | output | 1 | Node takes part in bus traffic |
| tx_pin_o | output | 1 | Transmit pin level |
| tx_oe_o | output | 1 | Transmit pin output enable |

## Verification
The hardest situation to reach is a dominant bit that arrives late in an integration run. It must restart the count without activating the node early. The stimulus first drives a partial run of recessive strobes and then a single dominant strobe. It then drives exactly one strobe fewer than the run length and shows that the node is still inactive. One more strobe then activates it. A request toggled between strobes is checked at the acknowledge output before any strobe arrives, to show that the bit boundary gates the mode change.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [1:0] {
        MODE_INTEG  = 2'd0,
        MODE_ACTIVE = 2'd1,
        MODE_CONFIG = 2'd2
    } can_mode_e;

    localparam logic LVL_RECESSIVE = 1'b1;
    localparam logic LVL_DOMINANT  = 1'b0;

    typedef struct packed {
        logic pin;
        logic oe;
    } tx_drive_t;

    // Pin level and enable for a given drive mode, participation and bit
    function automatic tx_drive_t tx_drive_of(logic push_pull, logic active, logic tx_bit);
        tx_drive_t d;
        logic      lvl;
        lvl = active ? tx_bit : LVL_RECESSIVE;
        if (push_pull) begin
            d.pin = lvl;
            d.oe  = 1'b1;
        end else begin
            d.pin = LVL_DOMINANT;
            d.oe  = (lvl == LVL_DOMINANT);
        end
        return d;
    endfunction

endpackage

// File: rtl/can_run_counter.sv
module can_run_counter #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(RUN_LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o = (cnt_q == LAST_VAL);
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic strobe_i,
    input  logic rx_i,
    input  logic run_last_i,
    output logic run_clr_o,
    output logic run_inc_o,
    output logic ack_o,
    output logic active_o
);
    can_mode_e state_q, state_d;

    always_comb begin
        state_d   = state_q;
        run_clr_o = 1'b0;
        run_inc_o = 1'b0;
        if (strobe_i) begin
            unique case (state_q)
                MODE_CONFIG: begin
                    if (!req_i) begin
                        state_d   = MODE_INTEG;
                        run_clr_o = 1'b1;
                    end
                end
                MODE_INTEG: begin
                    if (req_i) begin
                        state_d   = MODE_CONFIG;
                        run_clr_o = 1'b1;
                    end else if (rx_i != LVL_RECESSIVE) begin
                        run_clr_o = 1'b1;
                    end else if (run_last_i) begin
                        state_d   = MODE_ACTIVE;
                        run_clr_o = 1'b1;
                    end else begin
                        run_inc_o = 1'b1;
                    end
                end
                MODE_ACTIVE: begin
                    if (req_i) begin
                        state_d = MODE_CONFIG;
                    end
                end
                default: state_d = MODE_INTEG;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MODE_INTEG;
        end else begin
            state_q <= state_d;
        end
    end

    assign ack_o    = (state_q == MODE_CONFIG);
    assign active_o = (state_q == MODE_ACTIVE);
endmodule

// File: rtl/can_tx_drive.sv
module can_tx_drive
    import can_mode_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_wr_i,
    input  logic mode_pp_i,
    input  logic active_i,
    input  logic tx_bit_i,
    output logic pin_o,
    output logic oe_o
);
    logic      pp_q;
    tx_drive_t drv;

    always_ff @(posedge clk) begin
        if (rst) begin
            pp_q <= 1'b0;
        end else if (mode_wr_i) begin
            pp_q <= mode_pp_i;
        end
    end

    always_comb begin
        drv = tx_drive_of(pp_q, active_i, tx_bit_i);
    end

    assign pin_o = drv.pin;
    assign oe_o  = drv.oe;
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
    import can_mode_pkg::*;
#(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_req_i,
    input  logic bit_strobe_i,
    input  logic rx_bit_i,
    input  logic cfg_wr_i,
    input  logic drive_wr_i,
    input  logic drive_pp_i,
    input  logic tx_bit_i,
    output logic cfg_ack_o,
    output logic cfg_wr_en_o,
    output logic bus_active_o,
    output logic tx_pin_o,
    output logic tx_oe_o
);
    logic run_clr, run_inc, run_last;

    can_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (run_clr),
        .inc_i  (run_inc),
        .last_o (run_last)
    );

    can_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_i      (cfg_req_i),
        .strobe_i   (bit_strobe_i),
        .rx_i       (rx_bit_i),
        .run_last_i (run_last),
        .run_clr_o  (run_clr),
        .run_inc_o  (run_inc),
        .ack_o      (cfg_ack_o),
        .active_o   (bus_active_o)
    );

    can_tx_drive u_drv (
        .clk       (clk),
        .rst       (rst),
        .mode_wr_i (drive_wr_i),
        .mode_pp_i (drive_pp_i),
        .active_i  (bus_active_o),
        .tx_bit_i  (tx_bit_i),
        .pin_o     (tx_pin_o),
        .oe_o      (tx_oe_o)
    );

    assign cfg_wr_en_o = cfg_wr_i & cfg_ack_o;
endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic cfg_req_i,
    input logic bit_strobe_i,
    input logic rx_bit_i,
    input logic cfg_wr_i,
    input logic tx_bit_i,
    input logic cfg_ack_o,
    input logic cfg_wr_en_o,
    input logic bus_active_o,
    input logic tx_pin_o,
    input logic tx_oe_o
);
    AST_ACK_HOLDS_OFF_STROBE: assert property (@(posedge clk) disable iff (rst)
        !bit_strobe_i |=> $stable(cfg_ack_o)); // R3

    AST_ACK_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_ack_o) |-> $past(cfg_req_i) && $past(bit_strobe_i)); // R2

    AST_WR_LOCKED: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_en_o |-> cfg_ack_o && cfg_wr_i); // R8

    AST_ACTIVE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(bus_active_o && cfg_ack_o)); // R7

    AST_ACTIVE_AFTER_RECESSIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_active_o) |-> $past(bit_strobe_i) && $past(rx_bit_i) && !$past(cfg_req_i)); // R5

    AST_RECESSIVE_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (!bus_active_o || tx_bit_i) |-> (tx_pin_o == tx_oe_o)); // R10
endmodule

bind can_mode_ctrl can_mode_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_req_i    (cfg_req_i),
    .bit_strobe_i (bit_strobe_i),
    .rx_bit_i     (rx_bit_i),
    .cfg_wr_i     (cfg_wr_i),
    .tx_bit_i     (tx_bit_i),
    .cfg_ack_o    (cfg_ack_o),
    .cfg_wr_en_o  (cfg_wr_en_o),
    .bus_active_o (bus_active_o),
    .tx_pin_o     (tx_pin_o),
    .tx_oe_o      (tx_oe_o)
);

// File: tb/tb_can_mode_ctrl.sv
module tb_can_mode_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_req_i = 1'b0, bit_strobe_i = 1'b0, rx_bit_i = 1'b1;
    logic cfg_wr_i = 1'b0, drive_wr_i = 1'b0, drive_pp_i = 1'b0, tx_bit_i = 1'b1;
    logic cfg_ack_o, cfg_wr_en_o, bus_active_o, tx_pin_o, tx_oe_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    can_mode_ctrl dut (
        .clk(clk), .rst(rst), .cfg_req_i(cfg_req_i), .bit_strobe_i(bit_strobe_i),
        .rx_bit_i(rx_bit_i), .cfg_wr_i(cfg_wr_i), .drive_wr_i(drive_wr_i),
        .drive_pp_i(drive_pp_i), .tx_bit_i(tx_bit_i), .cfg_ack_o(cfg_ack_o),
        .cfg_wr_en_o(cfg_wr_en_o), .bus_active_o(bus_active_o),
        .tx_pin_o(tx_pin_o), .tx_oe_o(tx_oe_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // one bit strobe sampling rx, outputs checked at the following negedge
    task automatic strobe(input logic rx);
        rx_bit_i     = rx;
        bit_strobe_i = 1'b1;
        @(negedge clk);
        bit_strobe_i = 1'b0;
        rx_bit_i     = 1'b1;
    endtask

    task automatic strobes(input int n, input logic rx);
        for (int i = 0; i < n; i++) strobe(rx);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);
        check("R1 ack", cfg_ack_o, 1'b0);
        check("R1 active", bus_active_o, 1'b0);
        cfg_wr_i = 1'b1;
        check("R1 wr_en", cfg_wr_en_o, 1'b0);
        cfg_wr_i = 1'b0;
        check("R1 od idle oe", tx_oe_o, 1'b0);
    endtask

    task automatic t_integration_from_reset;
        strobes(10, 1'b1);
        check("R5 ten recessive", bus_active_o, 1'b0);
        strobe(1'b1);
        check("R5 eleventh recessive", bus_active_o, 1'b1);
    endtask

    task automatic t_enter_config;
        cfg_req_i = 1'b1;
        idle(3);
        check("R3 no strobe no ack", cfg_ack_o, 1'b0);
        check("R7 still active", bus_active_o, 1'b1);
        strobe(1'b1);
        check("R2 ack after strobe", cfg_ack_o, 1'b1);
        check("R7 active dropped", bus_active_o, 1'b0);
        cfg_wr_i = 1'b1;
        #1;
        check("R8 write passes", cfg_wr_en_o, 1'b1);
        cfg_wr_i = 1'b0;
        #1;
        check("R8 no write", cfg_wr_en_o, 1'b0);
    endtask

    task automatic t_leave_and_dominant;
        cfg_req_i = 1'b0;
        idle(2);
        check("R3 ack held off strobe", cfg_ack_o, 1'b1);
        strobe(1'b1);
        check("R4 ack cleared", cfg_ack_o, 1'b0);
        check("R4 not active", bus_active_o, 1'b0);
        cfg_wr_i = 1'b1;
        #1;
        check("R8 write locked", cfg_wr_en_o, 1'b0);
        cfg_wr_i = 1'b0;
        strobes(7, 1'b1);
        strobe(1'b0);
        strobes(10, 1'b1);
        check("R6 count restarted", bus_active_o, 1'b0);
        strobe(1'b1);
        check("R6 active after full run", bus_active_o, 1'b1);
    endtask

    task automatic t_req_during_integ;
        cfg_req_i = 1'b1;
        strobe(1'b1);
        cfg_req_i = 1'b0;
        strobe(1'b1);
        strobes(5, 1'b1);
        cfg_req_i = 1'b1;
        strobe(1'b1);
        check("R7 req in integration", cfg_ack_o, 1'b1);
        cfg_req_i = 1'b0;
        strobe(1'b1);
        strobes(10, 1'b1);
        check("R4 count cleared on exit", bus_active_o, 1'b0);
        strobe(1'b1);
        check("R5 active again", bus_active_o, 1'b1);
    endtask

    task automatic t_drive_modes;
        tx_bit_i = 1'b0;
        #1;
        check("R10 od dominant oe", tx_oe_o, 1'b1);
        check("R10 od dominant pin", tx_pin_o, 1'b0);
        tx_bit_i = 1'b1;
        #1;
        check("R10 od recessive oe", tx_oe_o, 1'b0);
        drive_pp_i = 1'b1;
        drive_wr_i = 1'b1;
        @(negedge clk);
        drive_wr_i = 1'b0;
        check("R9 pp oe", tx_oe_o, 1'b1);
        check("R11 pp recessive pin", tx_pin_o, 1'b1);
        tx_bit_i = 1'b0;
        #1;
        check("R11 pp dominant pin", tx_pin_o, 1'b0);
        cfg_req_i = 1'b1;
        strobe(1'b1);
        check("R11 idle pin recessive", tx_pin_o, 1'b1);
        check("R11 idle oe", tx_oe_o, 1'b1);
        drive_pp_i = 1'b0;
        drive_wr_i = 1'b1;
        @(negedge clk);
        drive_wr_i = 1'b0;
        check("R9 back to od", tx_oe_o, 1'b0);
        tx_bit_i = 1'b1;
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                t_reset();
                t_integration_from_reset();
                t_enter_config();
                t_leave_and_dominant();
                t_req_during_integ();
                t_drive_modes();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule